// File: doc/BRIEF.md
# Configurable Two-Plane Logic Array

This block evaluates a two-level sum of products over `N_IN` inputs, using `N_PT` product terms and `N_OUT` outputs. Configuration registers inside the block set both planes. Each product term reads any subset of the true and inverted forms of the inputs. In full mode, each output ORs any subset of the product terms.

When `fixed_or_i` is set, the OR plane becomes a fixed wiring. Output `o` then sums only its own contiguous group of `N_PT/N_OUT` terms, and the stored OR bits are ignored. The input-to-output path is purely combinational.

The configuration image is loaded through a one-bit serial port. The image holds `CFG_W = N_PT*2*N_IN + N_PT*N_OUT` bits. Outputs are held at zero until a complete image has been taken and the load port is idle.

Top module: `pla_array`

## Requirements
- R1: While `rst_ni` is low, `cfg_done_o` is 0 and `out_o` is all zero. Reset clears every configuration bit.
- R2: Product term `t` is the AND of its selected literals. Image bit `t*2*N_IN + 2k` selects input `k` in true form, and bit `t*2*N_IN + 2k + 1` selects it inverted.
- R3: A product term with no literal selected evaluates to 1. A term that selects both forms of the same input evaluates to 0.
- R4: With `fixed_or_i` = 0, output `o` is the OR of every term `t` whose image bit `N_PT*2*N_IN + o*N_PT + t` is set. An output with no term selected is 0.
- R5: With `fixed_or_i` = 1, output `o` is the OR of terms `o*G` through `o*G+G-1`, where `G = N_PT/N_OUT`. The OR-plane bits have no effect in this mode.
- R6: A load session is a run of cycles with `cfg_en_i` high. Each cycle of the session stores `cfg_bit_i` at the next image index. The first bit after `cfg_en_i` rises goes to index 0. Bits beyond index `CFG_W-1` are discarded.
- R7: `cfg_done_o` goes high on the clock edge that stores bit `CFG_W-1`. It stays high until a new session starts. A session that stops short leaves it low.
- R8: `out_o` is all zero whenever `cfg_en_i` is high or `cfg_done_o` is low.
- R9: Once configured and idle, `out_o` follows `in_i` and `fixed_or_i` within the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the configuration logic |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | High while configuration bits are shifted in |
| cfg_bit_i | input | 1 | Serial configuration data, image index 0 first |
| fixed_or_i | input | 1 | 1 selects the fixed grouped OR plane |
| in_i | input | N_IN | Logic inputs |
| out_o | output | N_OUT | Sum-of-products outputs |
| cfg_done_o | output | 1 | A complete image is held |

## Verification
The hardest cases to reach from the ports are the degenerate terms: an empty product, a self-contradicting product, and an output with no terms. A random image almost never produces them. A hand-built image therefore places one such term on each output. The same image is then read in both OR modes, so the grouped wiring, which ignores those OR bits, gives different answers from the full wiring. Session restart and overrun are reached by following a short aborted load with a full image plus surplus bits, and then checking that the surplus did not disturb the outputs.

// File: rtl/pla_pkg.sv
package pla_pkg;
  function automatic int unsigned and_bits(int unsigned n_in, int unsigned n_pt);
    return n_pt * 2 * n_in;
  endfunction

  function automatic int unsigned or_bits(int unsigned n_pt, int unsigned n_out);
    return n_pt * n_out;
  endfunction
endpackage

// File: rtl/pla_cfg_loader.sv
module pla_cfg_loader #(
  parameter int unsigned CFG_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic             cfg_bit_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             cfg_done_o
);
  localparam int unsigned CW = $clog2(CFG_W + 1);

  logic [CW-1:0]    cnt_q;
  logic             en_q;
  logic [CW-1:0]    idx;
  logic             room;
  logic [CFG_W-1:0] cfg_q;

  // a fresh session restarts at index 0
  assign idx  = (cfg_en_i && !en_q) ? '0 : cnt_q;
  assign room = idx < CW'(CFG_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      en_q <= cfg_en_i;
      if (cfg_en_i) cnt_q <= room ? idx + CW'(1) : idx;
    end
  end

  for (genvar i = 0; i < CFG_W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            cfg_q[i] <= 1'b0;
      else if (cfg_en_i && idx == CW'(i))     cfg_q[i] <= cfg_bit_i;
    end
  end

  assign cfg_o      = cfg_q;
  assign cfg_done_o = cnt_q == CW'(CFG_W);
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int unsigned N_IN = 6,
  parameter int unsigned N_PT = 8
) (
  input  logic [N_IN-1:0]        in_i,
  input  logic [N_PT*2*N_IN-1:0] sel_i,
  output logic [N_PT-1:0]        term_o
);
  localparam int unsigned LW = 2 * N_IN;

  logic [LW-1:0] lit;

  for (genvar k = 0; k < N_IN; k++) begin : g_lit
    assign lit[2*k]   = in_i[k];
    assign lit[2*k+1] = ~in_i[k];
  end

  // unselected literals read as 1
  for (genvar t = 0; t < N_PT; t++) begin : g_term
    assign term_o[t] = &(~sel_i[t*LW +: LW] | lit);
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int unsigned N_PT  = 8,
  parameter int unsigned N_OUT = 4
) (
  input  logic [N_PT-1:0]       term_i,
  input  logic [N_OUT*N_PT-1:0] sel_i,
  input  logic                  fixed_i,
  output logic [N_OUT-1:0]      out_o
);
  localparam int unsigned G = N_PT / N_OUT;

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [N_PT-1:0] grp;
    logic [N_PT-1:0] use_t;
    for (genvar t = 0; t < N_PT; t++) begin : g_grp
      assign grp[t] = (t / G) == o;
    end
    assign use_t    = fixed_i ? grp : sel_i[o*N_PT +: N_PT];
    assign out_o[o] = |(term_i & use_t);
  end
endmodule

// File: rtl/pla_array.sv
module pla_array
  import pla_pkg::*;
#(
  parameter int unsigned N_IN  = 6,
  parameter int unsigned N_PT  = 8,
  parameter int unsigned N_OUT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic             cfg_bit_i,
  input  logic             fixed_or_i,
  input  logic [N_IN-1:0]  in_i,
  output logic [N_OUT-1:0] out_o,
  output logic             cfg_done_o
);
  localparam int unsigned AND_W = and_bits(N_IN, N_PT);
  localparam int unsigned OR_W  = or_bits(N_PT, N_OUT);
  localparam int unsigned CFG_W = AND_W + OR_W;

  logic [CFG_W-1:0] cfg;
  logic             done;
  logic [N_PT-1:0]  term;
  logic [N_OUT-1:0] sum;

  pla_cfg_loader #(.CFG_W(CFG_W)) u_load (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_en_i  (cfg_en_i),
    .cfg_bit_i (cfg_bit_i),
    .cfg_o     (cfg),
    .cfg_done_o(done)
  );

  pla_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
    .in_i  (in_i),
    .sel_i (cfg[AND_W-1:0]),
    .term_o(term)
  );

  pla_or_plane #(.N_PT(N_PT), .N_OUT(N_OUT)) u_or (
    .term_i (term),
    .sel_i  (cfg[CFG_W-1:AND_W]),
    .fixed_i(fixed_or_i),
    .out_o  (sum)
  );

  assign out_o      = (cfg_en_i || !done) ? '0 : sum;
  assign cfg_done_o = done;
endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk #(
  parameter int unsigned N_IN  = 6,
  parameter int unsigned N_OUT = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_en_i,
  input logic             fixed_or_i,
  input logic [N_IN-1:0]  in_i,
  input logic [N_OUT-1:0] out_o,
  input logic             cfg_done_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk_i) !rst_ni |-> (!cfg_done_o && out_o == '0));

  // R8
  out_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_en_i || !cfg_done_o) |-> out_o == '0);

  // R7
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_done_o) |-> $past(cfg_en_i));

  // R7
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> $stable(cfg_done_o));

  // R6
  restart_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_en_i && !$past(cfg_en_i)) |=> !cfg_done_o);

  // R9
  comb_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_done_o && !cfg_en_i && $past(cfg_done_o) && !$past(cfg_en_i) &&
     $stable(in_i) && $stable(fixed_or_i)) |-> $stable(out_o));
endmodule

bind pla_array pla_array_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_en_i  (cfg_en_i),
  .fixed_or_i(fixed_or_i),
  .in_i      (in_i),
  .out_o     (out_o),
  .cfg_done_o(cfg_done_o)
);

// File: tb/pla_array_test.sv
`timescale 1ns/1ps
module pla_array_test;
  localparam int N_IN  = 6;
  localparam int N_PT  = 8;
  localparam int N_OUT = 4;
  localparam int G     = N_PT / N_OUT;
  localparam int LW    = 2 * N_IN;
  localparam int AND_W = N_PT * LW;
  localparam int CFG_W = AND_W + N_PT * N_OUT;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cfg_en_i = 1'b0;
  logic             cfg_bit_i = 1'b0;
  logic             fixed_or_i = 1'b0;
  logic [N_IN-1:0]  in_i = '0;
  logic [N_OUT-1:0] out_o;
  logic             cfg_done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit live = 0;

  logic [CFG_W-1:0] img;
  logic [CFG_W-1:0] mcfg;
  int               mcnt;
  bit               mprev;

  always #4 clk = ~clk;

  pla_array #(.N_IN(N_IN), .N_PT(N_PT), .N_OUT(N_OUT)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_en_i(cfg_en_i), .cfg_bit_i(cfg_bit_i),
    .fixed_or_i(fixed_or_i), .in_i(in_i), .out_o(out_o), .cfg_done_o(cfg_done_o)
  );

  // behavioural model of the load port
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mcfg = '0; mcnt = 0; mprev = 0;
    end else begin
      if (cfg_en_i) begin
        int idx;
        idx = mprev ? mcnt : 0;
        if (idx < CFG_W) begin
          mcfg[idx] = cfg_bit_i;
          mcnt = idx + 1;
        end else mcnt = idx;
      end
      mprev = cfg_en_i;
    end
  end

  function automatic logic [N_OUT-1:0] ref_out(logic [N_IN-1:0] x, logic fx);
    logic [N_PT-1:0]  term;
    logic [N_OUT-1:0] y;
    y = '0;
    for (int t = 0; t < N_PT; t++) begin
      term[t] = 1'b1;
      for (int k = 0; k < N_IN; k++) begin
        if (mcfg[t*LW + 2*k] && !x[k]) term[t] = 1'b0;
        if (mcfg[t*LW + 2*k + 1] && x[k]) term[t] = 1'b0;
      end
    end
    for (int o = 0; o < N_OUT; o++)
      for (int t = 0; t < N_PT; t++) begin
        bit s;
        s = fx ? (t / G == o) : mcfg[AND_W + o*N_PT + t];
        if (s && term[t]) y[o] = 1'b1;
      end
    return y;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni && live) begin
      bit               d;
      logic [N_OUT-1:0] e;
      d = (mcnt == CFG_W);
      e = (cfg_en_i || !d) ? '0 : ref_out(in_i, fixed_or_i);
      chk("R7 done", {31'd0, cfg_done_o}, {31'd0, d});
      chk((cfg_en_i || !d) ? "R8 gate" : (fixed_or_i ? "R5 fixed" : "R4 full"),
          {28'd0, out_o}, {28'd0, e});
    end
  end

  task automatic load(int nbits, int extra);
    for (int i = 0; i < nbits + extra; i++) begin
      @(posedge clk); #1;
      cfg_en_i  = 1'b1;
      cfg_bit_i = (i < nbits) ? img[i] : 1'b1;
    end
    @(posedge clk); #1;
    cfg_en_i = 1'b0;
  endtask

  task automatic sweep(logic fx);
    for (int v = 0; v < (1 << N_IN); v++) begin
      @(posedge clk); #1;
      fixed_or_i = fx;
      in_i = N_IN'(v);
    end
  endtask

  task automatic apply(logic fx, logic [N_IN-1:0] v);
    @(posedge clk); #1;
    fixed_or_i = fx;
    in_i = v;
    @(negedge clk);
  endtask

  initial begin
    #1200000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", {31'd0, cfg_done_o}, 32'd0);
    chk("R1 out", {28'd0, out_o}, 32'd0);
    @(posedge clk); #1;
    rst_ni = 1'b1;
    live = 1;

    // sparse pseudo-random image: R2, R4, R5 via model
    seed = 32'h1d3a;
    for (int i = 0; i < CFG_W; i++) begin
      seed = seed * 1103515245 + 12345;
      img[i] = (i < AND_W) ? (((seed >>> 16) % 6) == 0) : (((seed >>> 16) % 3) == 0);
    end
    load(CFG_W, 0);
    sweep(1'b0);
    sweep(1'b1);

    // short session: R7 done stays low, R8 outputs held at zero
    load(10, 0);
    apply(1'b0, 6'b111111);
    chk("R7 short session", {31'd0, cfg_done_o}, 32'd0);
    chk("R8 unconfigured", {28'd0, out_o}, 32'd0);

    // hand-built image with degenerate terms, plus surplus bits (R6)
    img = '0;
    img[1*LW + 0] = 1'b1; img[1*LW + 1] = 1'b1;              // term1: x0 & ~x0
    img[2*LW + 2] = 1'b1;                                    // term2: x1
    img[3*LW + 5] = 1'b1;                                    // term3: ~x2
    img[4*LW + 0] = 1'b1; img[4*LW + 6] = 1'b1;              // term4: x0 & x3
    for (int t = 5; t < N_PT; t++) begin
      img[t*LW + 10] = 1'b1; img[t*LW + 11] = 1'b1;          // contradiction
    end
    img[AND_W + 0*N_PT + 0] = 1'b1;                          // out0 <- empty term
    img[AND_W + 1*N_PT + 1] = 1'b1;                          // out1 <- contradiction
    img[AND_W + 3*N_PT + 2] = 1'b1;
    img[AND_W + 3*N_PT + 4] = 1'b1;
    load(CFG_W, 5);
    apply(1'b0, 6'b001010);
    chk("R6 overrun ignored", {31'd0, cfg_done_o}, 32'd1);
    chk("R3 R4 x1 x3", {28'd0, out_o}, 32'b1001);
    apply(1'b0, 6'b000000);
    chk("R3 empty and contradictory terms", {28'd0, out_o}, 32'b0001);
    apply(1'b0, 6'b001001);
    chk("R2 two-literal term", {28'd0, out_o}, 32'b1001);
    apply(1'b1, 6'b000100);
    chk("R5 groups x2", {28'd0, out_o}, 32'b0001);
    apply(1'b1, 6'b001001);
    chk("R5 groups x0 x3", {28'd0, out_o}, 32'b0111);

    // R9 same-cycle response
    @(posedge clk); #1;
    fixed_or_i = 1'b0;
    in_i = 6'b000010;
    #1;
    chk("R9 combinational", {28'd0, out_o}, 32'b1001);
    sweep(1'b0);
    sweep(1'b1);

    live = 0;
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule